// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits on the processor side of the interrupt path. At each instruction boundary it looks at three sources: a non-maskable request line (edge-latched), a maskable request line gated by the interrupt-enable flag, and a software-interrupt request that carries its own 8-bit type. It picks one by fixed priority and then runs the whole entry sequence without further help from the core. For a maskable request, that sequence starts with an acknowledge handshake that yields the vector byte.

After the type is known, the sequencer saves the context on the stack through a simple word-wide memory port. It pushes the flags first, then the code segment, then the instruction pointer. It then reads the handler offset and segment from the vector table at type times four. It presents the new code segment, instruction pointer and stack pointer, together with the flags with interrupt-enable and trap cleared. A one-cycle done pulse marks these values as loaded. The surrounding core supplies the context values and consumes the results.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only in a cycle where `boundary` is 1 and the sequencer is idle (`busy` = 0). Without a boundary, no request starts an entry.
- R2: A maskable request (`intr_in` = 1) is taken only when `ie_flag` = 1. With `ie_flag` = 0 it is ignored: no acknowledge pulse, no memory access, `busy` stays 0 and the outputs keep their values.
- R3: A rising edge on `nmi_in` is latched as pending until taken. It is taken whatever `ie_flag` is, uses type 2, and issues no acknowledge pulse.
- R4: Fixed priority when several requests meet at a boundary: non-maskable first, then software, then maskable. A request that loses stays available for a later boundary.
- R5: A maskable entry drives `ack_n` low twice, each pulse `ACK_LOW` cycles long with `ACK_GAP` high cycles between them. The vector type is sampled from `vec_bus` in the last low cycle of the second pulse only.
- R6: A software entry (`swi_valid` = 1) uses `swi_type` as the type and issues no acknowledge pulse.
- R7: Context is pushed as three word writes (`mem_we` = 1) in the order flags, code segment, instruction pointer. Each write first lowers the stack pointer by 2, so the k-th write (k = 1..3) goes to physical address `ss_in`*16 + (`sp_in` − 2k) mod 2^16. `new_sp` = `sp_in` − 6.
- R8: After the pushes, two word reads (`mem_we` = 0) fetch the handler offset from address type*4 and the segment from type*4+2. These become `new_ip` and `new_cs`.
- R9: `flags_out` equals the pushed flags with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R10: `done` is 1 for exactly one cycle, the cycle in which `new_cs`, `new_ip`, `new_sp` and `flags_out` take their new values. At all other times these outputs hold.
- R11: Each memory access keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until a cycle with `mem_ack` = 1 completes it. No access overlaps an acknowledge pulse.
- R12: After reset, `ack_n` = 1, `mem_req` = 0, `done` = 0, `busy` = 0, and `new_cs`, `new_ip`, `new_sp`, `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| intr_in | input | 1 | Maskable request, level sensitive |
| ie_flag | input | 1 | Interrupt-enable flag from the core |
| swi_valid | input | 1 | Software interrupt requested, held until taken |
| swi_type | input | 8 | Type of the software interrupt |
| boundary | input | 1 | Current instruction has completed |
| flags_in | input | 16 | Flags to save |
| cs_in | input | 16 | Code segment to save |
| ip_in | input | 16 | Return instruction pointer to save |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Stack pointer before entry |
| vec_bus | input | 8 | Vector byte driven by the controller |
| ack_n | output | 1 | Active-low acknowledge strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a stack write, 0 for a table read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current access |
| busy | output | 1 | An entry sequence is in progress |
| done | output | 1 | One-cycle pulse when results are loaded |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler offset |
| new_sp | output | 16 | Stack pointer after the pushes |
| flags_out | output | 16 | Flags with enable and trap cleared |

## Verification
The bench drives a decoy byte on `vec_bus` until the second acknowledge pulse begins. A sequencer that sampled during the first pulse or the gap would load the decoy's table entry. It raises the non-maskable edge together with a held maskable or software request: a wrong priority would show acknowledge pulses or a type other than 2 on the first entry, and a dropped loser would never be served. It holds a maskable request with the enable flag clear, and separately holds one with no boundary. A design that leaked either case would show `busy`, acknowledge pulses or memory traffic. Stack pointers near zero check the 16-bit wrap of the push addresses, and a memory model with random latency checks that each access waits for its acknowledge.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int WORD_W    = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PADDR_W   = WORD_W + SEG_SHIFT;
    localparam int VEC_W     = 8;
    localparam int IE_BIT    = 9;
    localparam int TF_BIT    = 8;
    localparam logic [VEC_W-1:0] NMI_TYPE = 8'd2;
    localparam logic [WORD_W-1:0] PUSH_STEP = 16'd2;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SWI,
        SRC_MASK
    } src_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_WAITV,
        C_PUSH_FL,
        C_PUSH_CS,
        C_PUSH_IP,
        C_RD_OFF,
        C_RD_SEG
    } core_e;

    typedef enum logic [1:0] {
        A_IDLE,
        A_P1,
        A_GAP,
        A_P2
    } ack_e;

    typedef struct packed {
        logic [WORD_W-1:0] flags;
        logic [WORD_W-1:0] cs;
        logic [WORD_W-1:0] ip;
        logic [WORD_W-1:0] ss;
        logic [WORD_W-1:0] sp;
    } ctx_t;

    function automatic logic [PADDR_W-1:0] phys_addr(input logic [WORD_W-1:0] seg,
                                                      input logic [WORD_W-1:0] off);
        return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
    endfunction

    function automatic logic [PADDR_W-1:0] table_addr(input logic [VEC_W-1:0] vec,
                                                       input logic half);
        return {{(PADDR_W-VEC_W-2){1'b0}}, vec, half, 1'b0};
    endfunction

    function automatic logic [WORD_W-1:0] entry_flags(input logic [WORD_W-1:0] f);
        logic [WORD_W-1:0] r;
        r = f;
        r[IE_BIT] = 1'b0;
        r[TF_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb
    import irq_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic             intr_in,
    input  logic             ie_flag,
    input  logic             swi_valid,
    input  logic [VEC_W-1:0] swi_type,
    input  logic             boundary,
    input  logic             ready,
    output logic             take,
    output src_e             src,
    output logic [VEC_W-1:0] take_type,
    output logic             nmi_pend
);

    logic nmi_prev;
    logic nmi_rise;

    assign nmi_rise = nmi_in && !nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            nmi_pend <= (nmi_pend && !(take && src == SRC_NMI)) || nmi_rise;
        end
    end

    always_comb begin
        src       = SRC_NONE;
        take_type = '0;
        if (boundary && ready) begin
            if (nmi_pend) begin
                src       = SRC_NMI;
                take_type = NMI_TYPE;
            end else if (swi_valid) begin
                src       = SRC_SWI;
                take_type = swi_type;
            end else if (intr_in && ie_flag) begin
                src       = SRC_MASK;
            end
        end
    end

    assign take = (src != SRC_NONE);

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_seq_pkg::*;
#(
    parameter int ACK_LOW = 2,
    parameter int ACK_GAP = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VEC_W-1:0] vec_bus,
    output logic             ack_n,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_out
);

    localparam int MAXLEN = (ACK_LOW > ACK_GAP) ? ACK_LOW : ACK_GAP;
    localparam int CNT_W  = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(ACK_LOW - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(ACK_GAP - 1);

    ack_e             st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= A_IDLE;
            cnt       <= '0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= 1'b0;
            case (st)
                A_IDLE: begin
                    if (start) begin
                        st  <= A_P1;
                        cnt <= '0;
                    end
                end
                A_P1: begin
                    if (cnt == LOW_LAST) begin
                        st  <= A_GAP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                A_GAP: begin
                    if (cnt == GAP_LAST) begin
                        st  <= A_P2;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                A_P2: begin
                    if (cnt == LOW_LAST) begin
                        st        <= A_IDLE;
                        cnt       <= '0;
                        vec_out   <= vec_bus;
                        vec_valid <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= A_IDLE;
            endcase
        end
    end

    assign ack_n = !(st == A_P1 || st == A_P2);

endmodule

// File: rtl/irq_seq_core.sv
module irq_seq_core
    import irq_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  src_e               src,
    input  logic [VEC_W-1:0]   take_type,
    input  ctx_t               ctx_in,
    input  logic               vec_valid,
    input  logic [VEC_W-1:0]   vec_in,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               ack_start,
    output logic               idle,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [WORD_W-1:0]  new_cs,
    output logic [WORD_W-1:0]  new_ip,
    output logic [WORD_W-1:0]  new_sp,
    output logic [WORD_W-1:0]  flags_out,
    output logic               done
);

    core_e             st;
    ctx_t              ctx;
    logic [VEC_W-1:0]  vtype;
    logic [WORD_W-1:0] sp_w;
    logic [WORD_W-1:0] sp_dec;
    logic [WORD_W-1:0] off_tmp;
    logic              pushing;

    assign idle      = (st == C_IDLE);
    assign ack_start = take && (src == SRC_MASK);
    assign sp_dec    = sp_w - PUSH_STEP;
    assign pushing   = (st == C_PUSH_FL) || (st == C_PUSH_CS) || (st == C_PUSH_IP);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (pushing) begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = phys_addr(ctx.ss, sp_dec);
            case (st)
                C_PUSH_FL: mem_wdata = ctx.flags;
                C_PUSH_CS: mem_wdata = ctx.cs;
                default:   mem_wdata = ctx.ip;
            endcase
        end else if (st == C_RD_OFF) begin
            mem_req  = 1'b1;
            mem_addr = table_addr(vtype, 1'b0);
        end else if (st == C_RD_SEG) begin
            mem_req  = 1'b1;
            mem_addr = table_addr(vtype, 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= C_IDLE;
            ctx       <= '0;
            vtype     <= '0;
            sp_w      <= '0;
            off_tmp   <= '0;
            new_cs    <= '0;
            new_ip    <= '0;
            new_sp    <= '0;
            flags_out <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                C_IDLE: begin
                    if (take) begin
                        ctx   <= ctx_in;
                        sp_w  <= ctx_in.sp;
                        vtype <= take_type;
                        st    <= (src == SRC_MASK) ? C_WAITV : C_PUSH_FL;
                    end
                end
                C_WAITV: begin
                    if (vec_valid) begin
                        vtype <= vec_in;
                        st    <= C_PUSH_FL;
                    end
                end
                C_PUSH_FL, C_PUSH_CS, C_PUSH_IP: begin
                    if (mem_ack) begin
                        sp_w <= sp_dec;
                        case (st)
                            C_PUSH_FL: st <= C_PUSH_CS;
                            C_PUSH_CS: st <= C_PUSH_IP;
                            default:   st <= C_RD_OFF;
                        endcase
                    end
                end
                C_RD_OFF: begin
                    if (mem_ack) begin
                        off_tmp <= mem_rdata;
                        st      <= C_RD_SEG;
                    end
                end
                C_RD_SEG: begin
                    if (mem_ack) begin
                        new_ip    <= off_tmp;
                        new_cs    <= mem_rdata;
                        new_sp    <= sp_w;
                        flags_out <= entry_flags(ctx.flags);
                        done      <= 1'b1;
                        st        <= C_IDLE;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int ACK_LOW = 2,
    parameter int ACK_GAP = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_in,
    input  logic               intr_in,
    input  logic               ie_flag,
    input  logic               swi_valid,
    input  logic [VEC_W-1:0]   swi_type,
    input  logic               boundary,
    input  logic [WORD_W-1:0]  flags_in,
    input  logic [WORD_W-1:0]  cs_in,
    input  logic [WORD_W-1:0]  ip_in,
    input  logic [WORD_W-1:0]  ss_in,
    input  logic [WORD_W-1:0]  sp_in,
    input  logic [VEC_W-1:0]   vec_bus,
    output logic               ack_n,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic               busy,
    output logic               done,
    output logic [WORD_W-1:0]  new_cs,
    output logic [WORD_W-1:0]  new_ip,
    output logic [WORD_W-1:0]  new_sp,
    output logic [WORD_W-1:0]  flags_out
);

    logic             take;
    src_e             src;
    logic [VEC_W-1:0] take_type;
    logic             nmi_pend;
    logic             idle;
    logic             ack_start;
    logic             vec_valid;
    logic [VEC_W-1:0] vec_cap;
    ctx_t             ctx_in;

    assign ctx_in = '{flags: flags_in, cs: cs_in, ip: ip_in, ss: ss_in, sp: sp_in};
    assign busy   = !idle;

    irq_req_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .nmi_in    (nmi_in),
        .intr_in   (intr_in),
        .ie_flag   (ie_flag),
        .swi_valid (swi_valid),
        .swi_type  (swi_type),
        .boundary  (boundary),
        .ready     (idle),
        .take      (take),
        .src       (src),
        .take_type (take_type),
        .nmi_pend  (nmi_pend)
    );

    irq_ack_ctrl #(
        .ACK_LOW (ACK_LOW),
        .ACK_GAP (ACK_GAP)
    ) u_ack (
        .clk       (clk),
        .rst       (rst),
        .start     (ack_start),
        .vec_bus   (vec_bus),
        .ack_n     (ack_n),
        .vec_valid (vec_valid),
        .vec_out   (vec_cap)
    );

    irq_seq_core u_core (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .src       (src),
        .take_type (take_type),
        .ctx_in    (ctx_in),
        .vec_valid (vec_valid),
        .vec_in    (vec_cap),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .ack_start (ack_start),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .new_cs    (new_cs),
        .new_ip    (new_ip),
        .new_sp    (new_sp),
        .flags_out (flags_out),
        .done      (done)
    );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
    import irq_seq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               intr_in,
    input logic               ie_flag,
    input logic               swi_valid,
    input logic               boundary,
    input logic               nmi_pend,
    input logic               ack_n,
    input logic               mem_req,
    input logic               mem_we,
    input logic [PADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0]  mem_wdata,
    input logic               mem_ack,
    input logic               busy,
    input logic               done,
    input logic [WORD_W-1:0]  new_cs,
    input logic [WORD_W-1:0]  new_ip
);

    // R1
    no_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !boundary) |=> !busy);

    // R2
    mask_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && boundary && intr_in && !ie_flag && !swi_valid && !nmi_pend) |=> (!busy && ack_n));

    // R5
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ack_n);

    // R11
    ack_mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !ack_n));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(new_cs) && $stable(new_ip)));

endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .intr_in   (intr_in),
    .ie_flag   (ie_flag),
    .swi_valid (swi_valid),
    .boundary  (boundary),
    .nmi_pend  (nmi_pend),
    .ack_n     (ack_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .busy      (busy),
    .done      (done),
    .new_cs    (new_cs),
    .new_ip    (new_ip)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    localparam int ACK_LOW = 2;
    localparam int ACK_GAP = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_in = 0, intr_in = 0, ie_flag = 0, swi_valid = 0, boundary = 0;
    logic [7:0]  swi_type = 0, vec_bus = 0;
    logic [15:0] flags_in = 0, cs_in = 0, ip_in = 0, ss_in = 0, sp_in = 0;
    logic        ack_n, mem_req, mem_we, busy, done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = 0, new_cs, new_ip, new_sp, flags_out;
    logic        mem_ack = 0;

    irq_entry_seq #(.ACK_LOW(ACK_LOW), .ACK_GAP(ACK_GAP)) u_dut (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .intr_in(intr_in), .ie_flag(ie_flag),
        .swi_valid(swi_valid), .swi_type(swi_type), .boundary(boundary),
        .flags_in(flags_in), .cs_in(cs_in), .ip_in(ip_in), .ss_in(ss_in), .sp_in(sp_in),
        .vec_bus(vec_bus), .ack_n(ack_n), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done(done), .new_cs(new_cs), .new_ip(new_ip),
        .new_sp(new_sp), .flags_out(flags_out)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // observation state written by the responder loop
    int          pulses, w1, w2, gap_cnt, gap_w, cur_low, done_cnt, n_wr, n_rd;
    logic        prev_ack;
    logic [19:0] wr_addr [8];
    logic [15:0] wr_data [8];
    logic [19:0] rd_addr [8];
    logic [7:0]  real_vec;
    logic [7:0]  decoy_vec;

    function automatic logic [15:0] rd_word(input logic [19:0] a);
        return (a[15:0] ^ 16'h5A3C) + {12'h0, a[19:16]} + 16'd17;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_obs();
        pulses = 0; w1 = 0; w2 = 0; gap_cnt = 0; gap_w = 0; cur_low = 0;
        done_cnt = 0; n_wr = 0; n_rd = 0;
    endtask

    // memory and vector responder, driven away from the active edge
    initial begin
        prev_ack = 1'b1;
        clear_obs();
        forever begin
            @(negedge clk);
            if (!ack_n) begin
                if (prev_ack) begin
                    pulses++;
                    cur_low = 0;
                    if (pulses == 2) gap_w = gap_cnt;
                end
                cur_low++;
                if (pulses == 1) w1 = cur_low;
                else if (pulses == 2) w2 = cur_low;
            end else if (pulses == 1) begin
                gap_cnt++;
            end
            prev_ack = ack_n;
            vec_bus = (pulses >= 2) ? real_vec : decoy_vec;
            if (done) done_cnt++;
            if (mem_req && ($urandom % 3 != 0)) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    if (n_wr < 8) begin
                        wr_addr[n_wr] = mem_addr;
                        wr_data[n_wr] = mem_wdata;
                    end
                    n_wr++;
                    mem_rdata = 16'hDEAD;
                end else begin
                    if (n_rd < 8) rd_addr[n_rd] = mem_addr;
                    n_rd++;
                    mem_rdata = rd_word(mem_addr);
                end
            end else begin
                mem_ack = 1'b0;
                mem_rdata = 16'hDEAD;
            end
        end
    end

    task automatic set_ctx();
        flags_in = 16'($urandom);
        cs_in    = 16'($urandom);
        ip_in    = 16'($urandom);
        ss_in    = 16'($urandom);
        sp_in    = 16'($urandom);
    endtask

    task automatic pulse_boundary();
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
    endtask

    task automatic nmi_edge();
        @(negedge clk);
        nmi_in = 1'b1;
        @(negedge clk);
        nmi_in = 1'b0;
        @(negedge clk);
    endtask

    // pulse a boundary, wait for the entry to finish, check everything
    task automatic run_evt(input string req, input logic [7:0] exp_type, input int exp_pulses);
        logic [15:0] sp_k;
        logic [15:0] exp_w [3];
        int waited;
        exp_w[0] = flags_in; exp_w[1] = cs_in; exp_w[2] = ip_in;
        clear_obs();
        pulse_boundary();
        waited = 0;
        while (done_cnt == 0 && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(done_cnt == 1, req, "R10 done seen once", done_cnt, 1);
        chk(new_ip == rd_word({10'h0, exp_type, 2'b00}), req, "R8 new_ip", new_ip,
            rd_word({10'h0, exp_type, 2'b00}));
        chk(new_cs == rd_word({10'h0, exp_type, 2'b10}), req, "R8 new_cs", new_cs,
            rd_word({10'h0, exp_type, 2'b10}));
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, req, "R10 done one cycle", done_cnt, 1);
        chk(pulses == exp_pulses, req, "R5 ack pulse count", pulses, exp_pulses);
        if (exp_pulses == 2) begin
            chk(w1 == ACK_LOW, req, "R5 first pulse width", w1, ACK_LOW);
            chk(w2 == ACK_LOW, req, "R5 second pulse width", w2, ACK_LOW);
            chk(gap_w == ACK_GAP, req, "R5 gap width", gap_w, ACK_GAP);
        end
        chk(n_wr == 3, req, "R7 push count", n_wr, 3);
        chk(n_rd == 2, req, "R8 read count", n_rd, 2);
        sp_k = sp_in;
        for (int k = 0; k < 3; k++) begin
            sp_k = sp_k - 16'd2;
            if (k < n_wr) begin
                chk(wr_addr[k] == {ss_in, 4'h0} + {4'h0, sp_k}, req, "R7 push addr",
                    wr_addr[k], {ss_in, 4'h0} + {4'h0, sp_k});
                chk(wr_data[k] == exp_w[k], req, "R7 push data", wr_data[k], exp_w[k]);
            end
        end
        if (n_rd == 2) begin
            chk(rd_addr[0] == {10'h0, exp_type, 2'b00}, req, "R8 offset addr", rd_addr[0],
                {10'h0, exp_type, 2'b00});
            chk(rd_addr[1] == {10'h0, exp_type, 2'b10}, req, "R8 segment addr", rd_addr[1],
                {10'h0, exp_type, 2'b10});
        end
        chk(new_sp == sp_in - 16'd6, req, "R7 new_sp", new_sp, sp_in - 16'd6);
        chk(flags_out == (flags_in & 16'hFCFF), req, "R9 flags_out", flags_out,
            flags_in & 16'hFCFF);
        chk(busy == 1'b0, req, "busy after entry", busy, 0);
    endtask

    task automatic quiet_window(input string req, input int cycles);
        int saw_busy;
        int saw_mem;
        logic [15:0] cs_before;
        cs_before = new_cs;
        saw_busy = 0; saw_mem = 0;
        clear_obs();
        repeat (cycles) begin
            @(negedge clk);
            if (busy) saw_busy++;
            if (mem_req) saw_mem++;
        end
        chk(saw_busy == 0, req, "busy stayed low", saw_busy, 0);
        chk(saw_mem == 0, req, "no memory access", saw_mem, 0);
        chk(pulses == 0, req, "no ack pulse", pulses, 0);
        chk(new_cs == cs_before, req, "new_cs held", new_cs, cs_before);
    endtask

    initial begin
        int iter;
        void'($urandom(32'd4711));
        decoy_vec = 8'hE7;
        real_vec  = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(ack_n == 1'b1, "R12", "ack_n", ack_n, 1);
        chk(mem_req == 1'b0, "R12", "mem_req", mem_req, 0);
        chk(done == 1'b0 && busy == 1'b0, "R12", "done/busy", {done, busy}, 0);
        chk(new_cs == 0 && new_ip == 0 && new_sp == 0 && flags_out == 0, "R12", "outputs",
            {new_cs, new_ip}, 0);

        // R6 software entry, no acknowledge
        set_ctx(); swi_type = 8'h50; swi_valid = 1'b1;
        run_evt("R6", 8'h50, 0);
        swi_valid = 1'b0;

        // R5 maskable entry with decoy before second pulse
        set_ctx(); ie_flag = 1'b1; intr_in = 1'b1; real_vec = 8'h3B;
        run_evt("R5", 8'h3B, 2);
        intr_in = 1'b0;

        // R2 maskable ignored while enable clear, with boundaries present
        ie_flag = 1'b0; intr_in = 1'b1;
        fork
            begin
                repeat (6) pulse_boundary();
            end
            quiet_window("R2", 14);
        join
        intr_in = 1'b0;

        // R1 no entry without a boundary
        ie_flag = 1'b1; intr_in = 1'b1;
        quiet_window("R1", 20);
        set_ctx(); real_vec = 8'hFF;
        run_evt("R1", 8'hFF, 2);
        intr_in = 1'b0;

        // R3 non-maskable with enable clear, latched before the boundary
        ie_flag = 1'b0;
        set_ctx();
        nmi_edge();
        repeat (5) @(negedge clk);
        run_evt("R3", 8'd2, 0);

        // R4 non-maskable beats maskable, maskable served next
        ie_flag = 1'b1; intr_in = 1'b1; real_vec = 8'h81;
        set_ctx();
        nmi_edge();
        run_evt("R4", 8'd2, 0);
        set_ctx();
        run_evt("R4", 8'h81, 2);
        intr_in = 1'b0;

        // R4 non-maskable beats software, software then software beats maskable
        swi_valid = 1'b1; swi_type = 8'h21; intr_in = 1'b1; real_vec = 8'h10;
        set_ctx();
        nmi_edge();
        run_evt("R4", 8'd2, 0);
        set_ctx();
        run_evt("R4", 8'h21, 0);
        swi_valid = 1'b0;
        set_ctx();
        run_evt("R4", 8'h10, 2);
        intr_in = 1'b0;

        // R7 stack pointer wrap near zero
        set_ctx(); sp_in = 16'h0002; swi_type = 8'h00; swi_valid = 1'b1;
        run_evt("R7", 8'h00, 0);
        swi_valid = 1'b0;
        set_ctx(); sp_in = 16'h0000; ss_in = 16'hFFFF; swi_type = 8'hFF; swi_valid = 1'b1;
        run_evt("R7", 8'hFF, 0);
        swi_valid = 1'b0;

        // random mix
        for (iter = 0; iter < 30; iter++) begin
            int kind;
            kind = $urandom_range(0, 2);
            set_ctx();
            if (kind == 0) begin
                swi_type = 8'($urandom); swi_valid = 1'b1;
                run_evt("R6", swi_type, 0);
                swi_valid = 1'b0;
            end else if (kind == 1) begin
                ie_flag = 1'b1; intr_in = 1'b1; real_vec = 8'($urandom);
                decoy_vec = ~real_vec;
                run_evt("R5", real_vec, 2);
                intr_in = 1'b0;
            end else begin
                ie_flag = 1'($urandom);
                nmi_edge();
                run_evt("R3", 8'd2, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule